// File: doc/BRIEF.md
# Read-Sequence Nonvolatile Command Decoder

This block sits on the access path of a nonvolatile-backed memory and watches every access strobe. Five reads at fixed key addresses, in a fixed order and with no other access between them, arm it; the address of the sixth read then picks one of four commands: store to the nonvolatile array, recall from it, turn automatic store off, or turn automatic store on. A decoded command appears as a single-cycle pulse with a two-bit code. Separate command sequencers consume the pulse and run the operation itself.

Accesses are single-cycle strobes with a read/write flag and a 16-bit address. Cycles with no strobe do not count as accesses and leave the series intact. While the operation is running, the surrounding logic holds the enable input low. During that time every access is discarded and the matcher is held at its start. Address comparison goes through a parameterised mask, and by default all 16 bits are compared.

Top module: `rdseq_cmd_decoder`

## Requirements
- R1: After reset the matcher is idle and `cmd_valid_o` is low. A lone read of a command address from idle gives no pulse.
- R2: Reads, in this order, at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, followed by a read at 0x8FC0, raise `cmd_valid_o` for exactly one cycle, in the cycle after the sixth read is sampled, with `cmd_code_o` = 0 (store).
- R3: The same five reads followed by a read at 0x4C63 pulse with `cmd_code_o` = 1 (recall).
- R4: A sixth read at 0x8B45 pulses with code 2 (automatic store off). A sixth read at 0x4B46 pulses with code 3 (automatic store on).
- R5: A read at any other address among the first five steps aborts the series. The remaining keys and a command address read after it give no pulse.
- R6: A write access at any step, whatever its address, returns the matcher to idle, and that series gives no pulse.
- R7: An aborting read whose address is 0x4E38 counts as the first key, so the series continues from the second key.
- R8: A sixth read at an address that is neither a command address nor 0x4E38 returns the matcher to idle with no pulse.
- R9: While `en_i` is low, accesses are discarded, the matcher returns to idle and no pulse is produced.
- R10: Cycles with `acc_valid_i` low between accesses do not break a series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | High when the device accepts accesses; held low while an operation runs |
| acc_valid_i | input | 1 | One access in this cycle |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_addr_i | input | 16 | Access address |
| cmd_valid_o | output | 1 | Single-cycle command pulse |
| cmd_code_o | output | 2 | Command code: 0 store, 1 recall, 2 automatic store off, 3 automatic store on; meaningful with the pulse |

## Verification
The assertions take as given that the inputs are synchronous to the clock, carry known values in every cycle, and that one strobe cycle is one access. They also rely on the pulse only ever following a cycle in which an enabled read was sampled. The bench changes inputs only on the falling edge, uses single-cycle strobes with idle gaps, and never leaves the address or flags unknown. It toggles `en_i` only in a way that keeps the inputs stable around the rising edge.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  localparam int SEQ_LEN = 6;
  localparam int N_KEYS  = SEQ_LEN - 1;
  localparam int N_CMDS  = 4;
  localparam int CODE_W  = $clog2(N_CMDS);

  typedef enum logic [CODE_W-1:0] {
    CMD_STORE    = 2'd0,
    CMD_RECALL   = 2'd1,
    CMD_AUTO_OFF = 2'd2,
    CMD_AUTO_ON  = 2'd3
  } cmd_e;

  function automatic logic [15:0] key_addr(input int idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  // index equals the command code
  function automatic logic [15:0] cmd_addr(input int idx);
    case (idx)
      0:       return 16'h8FC0;
      1:       return 16'h4C63;
      2:       return 16'h8B45;
      default: return 16'h4B46;
    endcase
  endfunction
endpackage

// File: rtl/rdseq_addr_match.sv
module rdseq_addr_match
  import rdseq_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CMP_MASK = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_KEYS-1:0] key_hit_o,
  output logic [N_CMDS-1:0] cmd_hit_o
);
  for (genvar k = 0; k < N_KEYS; k++) begin : g_key
    localparam logic [ADDR_W-1:0] KEY = ADDR_W'(key_addr(k));
    assign key_hit_o[k] = ((addr_i ^ KEY) & CMP_MASK) == '0;
  end

  for (genvar c = 0; c < N_CMDS; c++) begin : g_cmd
    localparam logic [ADDR_W-1:0] CODE = ADDR_W'(cmd_addr(c));
    assign cmd_hit_o[c] = ((addr_i ^ CODE) & CMP_MASK) == '0;
  end
endmodule

// File: rtl/rdseq_cmd_enc.sv
module rdseq_cmd_enc
  import rdseq_pkg::*;
(
  input  logic [N_CMDS-1:0] cmd_hit_i,
  output logic              any_o,
  output cmd_e              code_o
);
  // lowest index wins if a wide mask makes codes alias
  always_comb begin
    any_o  = 1'b0;
    code_o = CMD_STORE;
    for (int i = N_CMDS - 1; i >= 0; i--) begin
      if (cmd_hit_i[i]) begin
        any_o  = 1'b1;
        code_o = cmd_e'(i);
      end
    end
  end
endmodule

// File: rtl/rdseq_step_fsm.sv
module rdseq_step_fsm
  import rdseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [N_KEYS-1:0] key_hit_i,
  input  logic              cmd_any_i,
  input  cmd_e              cmd_code_i,
  output logic              cmd_valid_o,
  output cmd_e              cmd_code_o
);
  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam int PAD_N  = 1 << STEP_W;

  logic [STEP_W-1:0] step_q, step_d;
  logic [PAD_N-1:0]  key_pad;
  logic              fire;
  logic              armed;

  assign key_pad = {{(PAD_N - N_KEYS){1'b0}}, key_hit_i};
  assign armed   = step_q == STEP_W'(N_KEYS);

  always_comb begin
    step_d = step_q;
    fire   = 1'b0;
    if (!en_i) begin
      step_d = '0;
    end else if (acc_valid_i) begin
      if (acc_write_i) begin
        step_d = '0;
      end else if (armed && cmd_any_i) begin
        step_d = '0;
        fire   = 1'b1;
      end else if (!armed && key_pad[step_q]) begin
        step_d = step_q + 1'b1;
      end else if (key_hit_i[0]) begin
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q      <= '0;
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= CMD_STORE;
    end else begin
      step_q      <= step_d;
      cmd_valid_o <= fire;
      if (fire) cmd_code_o <= cmd_code_i;
    end
  end
endmodule

// File: rtl/rdseq_cmd_decoder.sv
module rdseq_cmd_decoder
  import rdseq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CMP_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              cmd_valid_o,
  output logic [CODE_W-1:0] cmd_code_o
);
  logic [N_KEYS-1:0] key_hit;
  logic [N_CMDS-1:0] cmd_hit;
  logic              cmd_any;
  cmd_e              cmd_code;
  cmd_e              code_q;

  rdseq_addr_match #(.ADDR_W(ADDR_W), .CMP_MASK(CMP_MASK)) u_match (
    .addr_i    (acc_addr_i),
    .key_hit_o (key_hit),
    .cmd_hit_o (cmd_hit)
  );

  rdseq_cmd_enc u_enc (
    .cmd_hit_i (cmd_hit),
    .any_o     (cmd_any),
    .code_o    (cmd_code)
  );

  rdseq_step_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .key_hit_i   (key_hit),
    .cmd_any_i   (cmd_any),
    .cmd_code_i  (cmd_code),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (code_q)
  );

  assign cmd_code_o = code_q;
endmodule

// File: rtl/rdseq_cmd_decoder_chk.sv
module rdseq_cmd_decoder_chk
  import rdseq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CMP_MASK = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              cmd_valid_o,
  input logic [CODE_W-1:0] cmd_code_o
);
  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_pulse_after_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !cmd_valid_o);

  assert_write_no_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i) |=> !cmd_valid_o);

  assert_disabled_no_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !cmd_valid_o);

  // R3 and R4: the code reported names the address of the read that fired it
  assert_code_matches_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (((($past(acc_addr_i)) ^ ADDR_W'(cmd_addr(int'(cmd_code_o)))) & CMP_MASK) == '0));
endmodule

bind rdseq_cmd_decoder rdseq_cmd_decoder_chk #(.ADDR_W(ADDR_W), .CMP_MASK(CMP_MASK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_addr_i  (acc_addr_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_code_o  (cmd_code_o)
);

// File: tb/sim_rdseq_cmd_decoder.sv
`timescale 1ns/1ps
module sim_rdseq_cmd_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [15:0] acc_addr_i = 16'h0;
  logic        cmd_valid_o;
  logic [1:0]  cmd_code_o;

  always #10 clk_i = ~clk_i;

  rdseq_cmd_decoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_addr_i(acc_addr_i),
    .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o)
  );

  int    checks = 0;
  int    fails  = 0;
  int    pulses = 0;
  string cur_req = "R1";
  bit    done = 0;

  int keys  [5] = '{32'h4E38, 32'hB1C7, 32'h83E0, 32'h7C1F, 32'h703F};
  int codes [4] = '{32'h8FC0, 32'h4C63, 32'h8B45, 32'h4B46};

  // behavioural reference
  int step  = 0;
  bit exp_v = 0;
  int exp_c = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      step = 0; exp_v = 0;
    end else begin
      exp_v = 0;
      if (!en_i) step = 0;
      else if (acc_valid_i) begin
        int hit;
        hit = -1;
        for (int i = 0; i < 4; i++) if (int'(acc_addr_i) == codes[i]) hit = i;
        if (acc_write_i) step = 0;
        else if (step == 5 && hit >= 0) begin exp_v = 1; exp_c = hit; step = 0; end
        else if (step < 5 && int'(acc_addr_i) == keys[step]) step = step + 1;
        else if (int'(acc_addr_i) == keys[0]) step = 1;
        else step = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(cmd_valid_o === exp_v, cur_req, int'(cmd_valid_o), int'(exp_v));
      if (exp_v) check(int'(cmd_code_o) == exp_c, cur_req, int'(cmd_code_o), exp_c);
      if (cmd_valid_o === 1'b1) pulses++;
    end
  end

  task automatic rd(input int a);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_addr_i = a[15:0];
  endtask

  task automatic wr(input int a);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_addr_i = a[15:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      acc_valid_i = 1'b0; acc_write_i = 1'b0;
    end
  endtask

  task automatic keys_upto(input int first, input int last);
    for (int i = first; i <= last; i++) rd(keys[i]);
  endtask

  task automatic expect_pulses(input int n, input string req);
    idle(3);
    check(pulses == n, req, pulses, n);
    pulses = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(cmd_valid_o === 1'b0, "R1", int'(cmd_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cmd_valid_o === 1'b0, "R1", int'(cmd_valid_o), 0);
    cur_req = "R1"; rd(codes[0]); expect_pulses(0, "R1");

    cur_req = "R2"; keys_upto(0, 4); rd(codes[0]); expect_pulses(1, "R2");
    cur_req = "R3"; keys_upto(0, 4); rd(codes[1]); expect_pulses(1, "R3");
    cur_req = "R4"; keys_upto(0, 4); rd(codes[2]); keys_upto(0, 4); rd(codes[3]);
    expect_pulses(2, "R4");

    cur_req = "R5"; keys_upto(0, 2); rd(32'h1234); keys_upto(3, 4); rd(codes[0]);
    rd(keys[1]); keys_upto(2, 4); rd(codes[1]); expect_pulses(0, "R5");

    cur_req = "R6"; keys_upto(0, 3); wr(keys[4]); rd(codes[0]);
    keys_upto(0, 4); wr(codes[1]); rd(codes[1]); expect_pulses(0, "R6");

    cur_req = "R7"; keys_upto(0, 1); rd(keys[0]); keys_upto(1, 4); rd(codes[1]);
    keys_upto(0, 4); rd(keys[0]); keys_upto(1, 4); rd(codes[2]);
    expect_pulses(2, "R7");

    cur_req = "R8"; keys_upto(0, 4); rd(32'h0000); rd(codes[0]);
    keys_upto(0, 4); rd(keys[4]); rd(codes[3]); expect_pulses(0, "R8");

    cur_req = "R9"; keys_upto(0, 2);
    @(negedge clk_i); acc_valid_i = 1'b0; en_i = 1'b0;
    @(negedge clk_i); en_i = 1'b1;
    keys_upto(3, 4); rd(codes[0]);
    keys_upto(0, 4);
    @(negedge clk_i); en_i = 1'b0; acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_addr_i = 16'h8FC0;
    @(negedge clk_i); en_i = 1'b1; acc_valid_i = 1'b0;
    rd(codes[0]); expect_pulses(0, "R9");

    cur_req = "R10";
    for (int i = 0; i < 5; i++) begin rd(keys[i]); idle(i + 1); end
    rd(codes[3]); expect_pulses(1, "R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule